// File: doc/BRIEF.md
# Signed Saturating Add/Subtract Unit

This unit performs 32-bit two's-complement arithmetic that never wraps. When a sum or difference does not fit in the signed range, the output is pinned to the nearest extreme: 0x7FFFFFFF on positive overflow and 0x80000000 on negative overflow. There are four operations. Two are plain saturating add and saturating subtract. The other two first double the second operand B, clamping that doubling if it overflows, and then add it to or subtract it from operand A with a second clamp.

Each operation reports whether any clamp happened. A sticky flag gathers clamp events over many operations until a synchronous clear drops it. All outputs are registered and change on the clock edge that samples the valid strobe. The active-low reset is asserted asynchronously and released in step with the clock.

Top module: `sat_arith_unit`

## Requirements
- R1: While reset is applied, and after reset until the first valid operation, `res` is 0, `res_sat` is 0 and `sticky` is 0.
- R2: Op code 2'b00 outputs A+B. When the true sum fits in the signed 32-bit range, `res_sat` is 0.
- R3: On signed overflow of the add, the result is 0x7FFFFFFF if the true sum is positive and 0x80000000 if it is negative, and `res_sat` is 1.
- R4: Op code 2'b01 outputs A−B. It clamps to 0x7FFFFFFF or 0x80000000 by the same rule as R3 and sets `res_sat` when it clamps.
- R5: Op code 2'b10 outputs A + D, where D is 2·B clamped to the signed range. The final add also saturates.
- R6: Op code 2'b11 outputs A − D, with D formed as in R5. The final subtract also saturates.
- R7: `res_sat` is 1 exactly when the doubling step or the final add/subtract of that operation clamped.
- R8: `sticky` goes to 1 on the edge that registers an operation with `res_sat` = 1. It then stays at 1 until it is cleared.
- R9: `sticky_clr` clears `sticky` on the next edge. If a clamping operation is registered on that same edge, `sticky` ends at 1.
- R10: The results of an operation appear one clock edge after `in_vld` is sampled high. While `in_vld` is low, `res` and `res_sat` keep their values.
- R11: Only B is doubled. With B = 0, op 2'b10 returns A unchanged, even when 2·A would overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| in_vld | input | 1 | Operation strobe; operands and op code are sampled when high |
| op | input | 2 | 00 add, 01 subtract, 10 add doubled B, 11 subtract doubled B |
| opa | input | 32 | Operand A (signed) |
| opb | input | 32 | Operand B (signed) |
| sticky_clr | input | 1 | Synchronous clear of the sticky saturation flag |
| res | output | 32 | Saturated result |
| res_sat | output | 1 | Set when the last registered operation clamped |
| sticky | output | 1 | Accumulated clamp indication |

## Verification
Every result, saturation bit and sticky update becomes valid on the first rising edge after the strobe is sampled, so the latency is one cycle. The bench drives inputs on the falling edge and reads the outputs on the next falling edge, half a cycle after the registering edge. Hold behaviour is checked after idle cycles with the strobe low. The clear/set collision is checked by raising both inputs in the same cycle and then reading the flag one edge later.

// File: rtl/sat_arith_pkg.sv
package sat_arith_pkg;
  typedef enum logic [1:0] {
    SA_ADD  = 2'b00,
    SA_SUB  = 2'b01,
    SA_DADD = 2'b10,
    SA_DSUB = 2'b11
  } sa_op_e;
endpackage

// File: rtl/sat_rst_sync.sv
module sat_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/sat_double.sv
module sat_double #(
  parameter int W = 32
) (
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         clamp
);
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    clamp = b[W-1] ^ b[W-2];
    if (clamp) y = b[W-1] ? NEG_MIN : POS_MAX;
    else       y = {b[W-2:0], 1'b0};
  end
endmodule

// File: rtl/sat_addsub.sv
module sat_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y,
  output logic         clamp
);
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] b_eff;
  logic [W-1:0] raw;

  always_comb begin
    b_eff = sub ? ~b : b;
    raw   = a + b_eff + {{(W-1){1'b0}}, sub};
    clamp = (a[W-1] == b_eff[W-1]) && (raw[W-1] != a[W-1]);
    if (clamp) y = raw[W-1] ? POS_MAX : NEG_MIN;
    else       y = raw;
  end
endmodule

// File: rtl/sat_arith_unit.sv
module sat_arith_unit #(
  parameter int W = 32,
  parameter int RST_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [1:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         sticky_clr,
  output logic [W-1:0] res,
  output logic         res_sat,
  output logic         sticky
);
  import sat_arith_pkg::*;

  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  logic         rst_ns;
  sa_op_e       op_e;
  logic [W-1:0] dbl_y;
  logic         dbl_clamp;
  logic [W-1:0] rhs;
  logic [W-1:0] as_y;
  logic         as_clamp;
  logic         sat_now;

  logic [W-1:0] res_d, res_q;
  logic         sat_d, sat_q;
  logic         stk_d, stk_q;

  sat_rst_sync #(.STAGES(RST_STAGES)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_ns(rst_ns)
  );

  sat_double #(.W(W)) i_dbl (
    .b(opb), .y(dbl_y), .clamp(dbl_clamp)
  );

  always_comb begin
    op_e = sa_op_e'(op);
    rhs  = (op_e == SA_DADD || op_e == SA_DSUB) ? dbl_y : opb;
  end

  sat_addsub #(.W(W)) i_as (
    .a(opa), .b(rhs), .sub(op[0]), .y(as_y), .clamp(as_clamp)
  );

  always_comb begin
    sat_now = as_clamp | (op[1] & dbl_clamp);
    res_d   = res_q;
    sat_d   = sat_q;
    stk_d   = stk_q;
    if (sticky_clr) stk_d = 1'b0;
    if (in_vld) begin
      res_d = as_y;
      sat_d = sat_now;
      if (sat_now) stk_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      res_q <= '0;
      sat_q <= 1'b0;
      stk_q <= 1'b0;
    end else begin
      res_q <= res_d;
      sat_q <= sat_d;
      stk_q <= stk_d;
    end
  end

  assign res     = res_q;
  assign res_sat = sat_q;
  assign sticky  = stk_q;

  // R2
  add_exact_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (in_vld && op == 2'b00) |=> (res_sat || res == $past(opa + opb)));

  // R3
  add_clamp_extreme_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (in_vld && !op[1]) |=> (!res_sat || res == POS_MAX || res == NEG_MIN));

  // R8
  sat_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    in_vld |=> (!res_sat || sticky));

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!in_vld && !sticky_clr) |=> $stable(sticky));

  // R9
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (sticky_clr && !in_vld) |=> !sticky);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !in_vld |=> ($stable(res) && $stable(res_sat)));
endmodule

// File: tb/test_sat_arith_unit.sv
module test_sat_arith_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic        sticky_clr = 1'b0;
  logic [31:0] res;
  logic        res_sat;
  logic        sticky;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sat_arith_unit i_sat_arith_unit (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op(op), .opa(opa), .opb(opb),
    .sticky_clr(sticky_clr), .res(res), .res_sat(res_sat), .sticky(sticky)
  );

  // fields: op, a, b, expected result, expected saturation bit
  localparam int NV = 18;
  localparam logic [98:0] VEC [NV] = '{
    {2'b00, 32'h00000005, 32'h00000007, 32'h0000000C, 1'b0}, // R2
    {2'b00, 32'h7FFFFFFF, 32'h00000001, 32'h7FFFFFFF, 1'b1}, // R3
    {2'b00, 32'h80000000, 32'hFFFFFFFF, 32'h80000000, 1'b1}, // R3
    {2'b00, 32'h40000000, 32'h40000000, 32'h7FFFFFFF, 1'b1}, // R3
    {2'b00, 32'hC0000000, 32'hC0000000, 32'h80000000, 1'b0}, // R2 exact min
    {2'b01, 32'h80000000, 32'h00000001, 32'h80000000, 1'b1}, // R4
    {2'b01, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h7FFFFFFF, 1'b1}, // R4
    {2'b01, 32'h00000000, 32'h80000000, 32'h7FFFFFFF, 1'b1}, // R4
    {2'b01, 32'h0000000A, 32'h00000003, 32'h00000007, 1'b0}, // R4
    {2'b10, 32'h00000001, 32'h00000003, 32'h00000007, 1'b0}, // R5
    {2'b10, 32'h00000000, 32'h40000000, 32'h7FFFFFFF, 1'b1}, // R5 R7
    {2'b10, 32'h80000000, 32'h40000000, 32'hFFFFFFFF, 1'b1}, // R7 doubling only
    {2'b10, 32'hFFFFFFFF, 32'hC0000000, 32'h80000000, 1'b1}, // R7 add only
    {2'b10, 32'h40000000, 32'h00000000, 32'h40000000, 1'b0}, // R11
    {2'b11, 32'h00000000, 32'hC0000000, 32'h80000000 ^ 32'hFFFFFFFF, 1'b1}, // R6
    {2'b11, 32'h7FFFFFFF, 32'h80000000, 32'h7FFFFFFF, 1'b1}, // R6
    {2'b11, 32'h00000064, 32'h00000014, 32'h0000003C, 1'b0}, // R6
    {2'b11, 32'h00000000, 32'h7FFFFFFF, 32'h80000001, 1'b1}  // R6 R7
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void ref_op(input logic [1:0] o, input logic [31:0] a,
                                 input logic [31:0] b, output logic [31:0] r,
                                 output logic s);
    longint sa, sb, d, t;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    s = 1'b0;
    d = sb;
    if (o[1]) begin
      d = 2 * sb;
      if (d > 64'sd2147483647) begin d = 64'sd2147483647; s = 1'b1; end
      if (d < -64'sd2147483648) begin d = -64'sd2147483648; s = 1'b1; end
    end
    t = o[0] ? sa - d : sa + d;
    if (t > 64'sd2147483647) begin t = 64'sd2147483647; s = 1'b1; end
    if (t < -64'sd2147483648) begin t = -64'sd2147483648; s = 1'b1; end
    r = t[31:0];
  endfunction

  task automatic issue(logic [1:0] o, logic [31:0] a, logic [31:0] b, logic clr);
    @(negedge clk);
    in_vld = 1'b1; op = o; opa = a; opb = b; sticky_clr = clr;
    @(negedge clk);
    in_vld = 1'b0; sticky_clr = 1'b0;
  endtask

  initial begin
    logic [31:0] r;
    logic s;
    logic exp_stk;
    repeat (3) @(negedge clk);
    check("R1 res in reset", res, 32'h0);
    check("R1 sat in reset", {31'b0, res_sat}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 res after reset", res, 32'h0);
    check("R1 sticky after reset", {31'b0, sticky}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][98:97], VEC[i][96:65], VEC[i][64:33], 1'b0);
      check("R2-table result", res, VEC[i][32:1]);
      check("R7 table sat", {31'b0, res_sat}, {31'b0, VEC[i][0]});
    end

    // R10 hold while idle
    r = res;
    opa = 32'h12345678; opb = 32'h1; op = 2'b00;
    repeat (3) @(negedge clk);
    check("R10 res hold", res, r);
    check("R10 sat hold", {31'b0, res_sat}, 32'h1);
    check("R8 sticky set after clamps", {31'b0, sticky}, 32'h1);

    // R9 clear alone
    @(negedge clk); sticky_clr = 1'b1;
    @(negedge clk); sticky_clr = 1'b0;
    check("R9 sticky cleared", {31'b0, sticky}, 32'h0);
    issue(2'b00, 32'h1, 32'h2, 1'b0);
    check("R8 non-clamp keeps sticky low", {31'b0, sticky}, 32'h0);
    issue(2'b00, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b1);
    check("R9 set wins over clear", {31'b0, sticky}, 32'h1);
    repeat (2) @(negedge clk);
    check("R8 sticky holds", {31'b0, sticky}, 32'h1);

    // random against wide reference
    @(negedge clk); sticky_clr = 1'b1;
    @(negedge clk); sticky_clr = 1'b0;
    exp_stk = 1'b0;
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a, b;
      logic [1:0] o;
      a = $urandom; b = $urandom; o = 2'($urandom);
      if (k % 5 == 0) a = {a[31], {31{a[31]}} ^ 31'h1};
      if (k % 7 == 0) b = {b[31], ~b[31], b[29:0]};
      ref_op(o, a, b, r, s);
      issue(o, a, b, 1'b0);
      exp_stk = exp_stk | s;
      check("R5 R6 random result", res, r);
      check("R7 random sat", {31'b0, res_sat}, {31'b0, s});
      check("R8 random sticky", {31'b0, sticky}, {31'b0, exp_stk});
    end
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule